// File: doc/BRIEF.md
# Counter-Driven Block Copy and Line Plot Engine

This engine masters a byte-wide memory port to perform one of two jobs for a linear bitmap whose rows are 64 bytes long. In block mode it streams bytes from a contiguous source area into a rectangle of the destination, walking along a row and then stepping to the next row. In line mode it plots a straight run of bytes using a fill value. The run follows a major axis that moves every step and a minor axis that moves only when a fractional accumulator carries. Both jobs share one datapath: two up/down counters hold the destination column and row, and the address is formed from them.

Software sets up the configuration inputs: source address, destination base, start column and row, column count, span (rows or pixel count), slope increment, octant, mode, combine operation and fill byte. It then pulses start. The engine latches the whole configuration, raises busy, and requests memory cycles one at a time. Each request is held until the memory grants it. Read data is taken in the grant cycle. When the last write is granted, busy falls and done pulses for one cycle.

Every element takes either one plain write or a read of the destination followed by a write-back of the combined value. Block mode adds a source read in front of each element. The controller is a four-state machine. S_IDLE waits for start. S_SRC_RD fetches the next source byte. S_DST_RD fetches the destination byte for a combine. S_WRITE stores the result. The transitions are as follows. Start goes from S_IDLE to S_SRC_RD in block mode. In line mode it goes to S_DST_RD or S_WRITE. S_SRC_RD goes to S_DST_RD or S_WRITE on grant, depending on whether the operation combines. S_DST_RD goes to S_WRITE on grant. S_WRITE goes on grant to the first state of the next element, or back to S_IDLE after the last element. A zero-length start stays in S_IDLE.

Top module: `vecblit_engine`

## Requirements
- R1: After reset, busy, done and mem_req are low. While busy is low, no memory request is made.
- R2: In block mode (cfg_mode=0), source bytes are read from consecutive addresses starting at cfg_src. Element k of row r is written to base + ((y0+r) mod 256)*64 + ((x0+k) mod 64). Rows run from 0 to cfg_span-1 and columns from 0 to cfg_cols-1, in row-major order.
- R3: cfg_rop selects the combine. 00 is a plain write of the new byte with no destination read. 01 writes new OR old, 10 writes new AND old and 11 writes new XOR old. For these three codes the destination address is read first and the same address is then written.
- R4: In line mode (cfg_mode=1), no source reads occur. The new byte is cfg_fill, and exactly cfg_span elements are written.
- R5: In line mode, after each element the major axis moves by one and an 8-bit accumulator (cleared at start) adds cfg_slope. A carry out of bit 7 moves the minor axis by one. The octant bits select the axes and directions. cfg_octant[2]=1 makes Y the major axis. cfg_octant[1]=1 makes X count down. cfg_octant[0]=1 makes Y count down.
- R6: A request that is not granted stays asserted in the next cycle, with unchanged address, direction and write data.
- R7: Busy is high from the cycle after an accepted start until the last write is granted. In the following cycle done is high for exactly one cycle and busy is low.
- R8: A start pulse while busy is ignored. The running operation and its results are unchanged, and no second operation follows.
- R9: A start with a zero length produces a done pulse in the next cycle, with no memory request, and busy stays low. In block mode zero length means cfg_cols=0 or cfg_span=0. In line mode it means cfg_span=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| cfg_mode | input | 1 | 0 block copy, 1 line plot |
| cfg_rop | input | 2 | Combine code |
| cfg_octant | input | 3 | {Y major, X down, Y down} for line mode |
| cfg_src | input | ADDR_W | Source start address |
| cfg_base | input | ADDR_W | Destination bitmap base |
| cfg_x0 | input | X_W | Start column (byte) |
| cfg_y0 | input | Y_W | Start row |
| cfg_cols | input | X_W+1 | Bytes per row in block mode |
| cfg_span | input | Y_W+1 | Rows in block mode, element count in line mode |
| cfg_slope | input | FRAC_W | Accumulator increment for the minor axis |
| cfg_fill | input | DATA_W | Byte plotted in line mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until granted |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Grant; the transfer happens at the clock edge where req and gnt are both high |
| mem_rdata | input | DATA_W | Read data, valid in the grant cycle |

## Verification
Most internal faults show up at the memory port within one element. A wrong counter direction, a missed row wrap or a wrong accumulator carry puts the next write at a wrong address. A wrong state sequence makes a read appear where a write is due, or adds or drops a destination read. The expected transfer stream therefore flags such a fault at the first granted transfer that differs. Stalls are inserted at random to expose requests that change before they are granted. Faults in the final count or in the busy and done handshake appear at the end of the operation, as a missing, late or doubled done pulse, or as leftover expected transfers.

// File: rtl/blit_pkg.sv
package blit_pkg;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_SRC_RD = 2'd1,
        S_DST_RD = 2'd2,
        S_WRITE  = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        ROP_COPY = 2'b00,
        ROP_OR   = 2'b01,
        ROP_AND  = 2'b10,
        ROP_XOR  = 2'b11
    } rop_e;

    typedef struct packed {
        logic y_major;
        logic x_down;
        logic y_down;
    } octant_t;

endpackage

// File: rtl/blit_updown.sv
module blit_updown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         down,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (step) begin
            q <= down ? q - 1'b1 : q + 1'b1;
        end
    end
endmodule

// File: rtl/blit_slope.sv
module blit_slope #(
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [FRAC_W-1:0] inc,
    output logic              carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, inc};
    assign carry = sum[FRAC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else if (advance) begin
            acc_q <= sum[FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/blit_rop.sv
module blit_rop
    import blit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  rop_e              op,
    input  logic [DATA_W-1:0] new_byte,
    input  logic [DATA_W-1:0] old_byte,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        unique case (op)
            ROP_COPY: result = new_byte;
            ROP_OR:   result = new_byte | old_byte;
            ROP_AND:  result = new_byte & old_byte;
            ROP_XOR:  result = new_byte ^ old_byte;
            default:  result = new_byte;
        endcase
    end
endmodule

// File: rtl/vecblit_engine.sv
module vecblit_engine
    import blit_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int X_W    = 6,
    parameter int Y_W    = 8,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cfg_mode,
    input  logic [1:0]        cfg_rop,
    input  logic [2:0]        cfg_octant,
    input  logic [ADDR_W-1:0] cfg_src,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [X_W-1:0]    cfg_x0,
    input  logic [Y_W-1:0]    cfg_y0,
    input  logic [X_W:0]      cfg_cols,
    input  logic [Y_W:0]      cfg_span,
    input  logic [FRAC_W-1:0] cfg_slope,
    input  logic [DATA_W-1:0] cfg_fill,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int COL_W  = X_W + 1;
    localparam int SPAN_W = Y_W + 1;

    state_e              state_q, state_n;
    logic                line_q;
    rop_e                rop_q;
    octant_t             oct_q;
    logic [ADDR_W-1:0]   src_q, base_q, dst_addr;
    logic [X_W-1:0]      x0_q, x_q;
    logic [Y_W-1:0]      y_q;
    logic [COL_W-1:0]    cols_q, col_idx;
    logic [SPAN_W-1:0]   span_q, span_idx;
    logic [FRAC_W-1:0]   slope_q;
    logic [DATA_W-1:0]   fill_q, srcd_q, dstd_q, new_byte, comb_byte;
    logic                done_q;

    logic zero_len, accept, src_fire, dst_fire, wr_fire;
    logic row_end, span_last, last_elem, carry;
    logic x_load, x_step, x_down, y_load, y_step, y_down;
    logic [X_W-1:0] x_load_val;
    state_e first_state, after_write;

    // Start decode
    assign zero_len = cfg_mode ? (cfg_span == '0)
                               : ((cfg_cols == '0) || (cfg_span == '0));
    assign accept   = start && (state_q == S_IDLE) && !zero_len;
    assign src_fire = (state_q == S_SRC_RD) && mem_gnt;
    assign dst_fire = (state_q == S_DST_RD) && mem_gnt;
    assign wr_fire  = (state_q == S_WRITE)  && mem_gnt;

    assign row_end   = (col_idx  == cols_q - 1'b1);
    assign span_last = (span_idx == span_q - 1'b1);
    assign last_elem = line_q ? span_last : (row_end && span_last);

    assign first_state = cfg_mode ? ((cfg_rop == 2'b00) ? S_WRITE : S_DST_RD)
                                  : S_SRC_RD;
    assign after_write = line_q ? ((rop_q == ROP_COPY) ? S_WRITE : S_DST_RD)
                                : S_SRC_RD;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept) state_n = first_state;
            end
            S_SRC_RD: begin
                if (mem_gnt) state_n = (rop_q == ROP_COPY) ? S_WRITE : S_DST_RD;
            end
            S_DST_RD: begin
                if (mem_gnt) state_n = S_WRITE;
            end
            S_WRITE: begin
                if (mem_gnt) state_n = last_elem ? S_IDLE : after_write;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dst_addr;
        mem_wdata = comb_byte;
        unique case (state_q)
            S_IDLE: begin
                busy = 1'b0;
            end
            S_SRC_RD: begin
                busy     = 1'b1;
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            S_DST_RD: begin
                busy    = 1'b1;
                mem_req = 1'b1;
            end
            S_WRITE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: busy = 1'b0;
        endcase
    end
    assign done = done_q;

    // Configuration latch, source pointer, data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            rop_q   <= ROP_COPY;
            oct_q   <= '0;
            base_q  <= '0;
            x0_q    <= '0;
            cols_q  <= '0;
            span_q  <= '0;
            slope_q <= '0;
            fill_q  <= '0;
            src_q   <= '0;
            srcd_q  <= '0;
            dstd_q  <= '0;
        end else begin
            if (accept) begin
                line_q  <= cfg_mode;
                rop_q   <= rop_e'(cfg_rop);
                oct_q   <= octant_t'(cfg_octant);
                base_q  <= cfg_base;
                x0_q    <= cfg_x0;
                cols_q  <= cfg_cols;
                span_q  <= cfg_span;
                slope_q <= cfg_slope;
                fill_q  <= cfg_fill;
                src_q   <= cfg_src;
            end else if (src_fire) begin
                src_q <= src_q + 1'b1;
            end
            if (src_fire) srcd_q <= mem_rdata;
            if (dst_fire) dstd_q <= mem_rdata;
        end
    end

    // Element indices
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_idx  <= '0;
            span_idx <= '0;
        end else if (accept) begin
            col_idx  <= '0;
            span_idx <= '0;
        end else if (wr_fire) begin
            if (line_q) begin
                span_idx <= span_idx + 1'b1;
            end else if (row_end) begin
                col_idx  <= '0;
                span_idx <= span_idx + 1'b1;
            end else begin
                col_idx <= col_idx + 1'b1;
            end
        end
    end

    done_reg_block : begin end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= (wr_fire && last_elem) ||
                      (start && (state_q == S_IDLE) && zero_len);
        end
    end

    // Axis control: block walks rows, line steps major and carries minor
    always_comb begin
        x_load_val = accept ? cfg_x0 : x0_q;
        y_load     = accept;
        if (line_q) begin
            x_load = accept;
            x_step = wr_fire && (oct_q.y_major ? carry : 1'b1);
            x_down = oct_q.x_down;
            y_step = wr_fire && (oct_q.y_major ? 1'b1 : carry);
            y_down = oct_q.y_down;
        end else begin
            x_load = accept || (wr_fire && row_end);
            x_step = wr_fire && !row_end;
            x_down = 1'b0;
            y_step = wr_fire && row_end;
            y_down = 1'b0;
        end
    end

    blit_updown #(.W(X_W)) u_xcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (x_load),
        .load_val (x_load_val),
        .step     (x_step),
        .down     (x_down),
        .q        (x_q)
    );

    blit_updown #(.W(Y_W)) u_ycnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (y_load),
        .load_val (cfg_y0),
        .step     (y_step),
        .down     (y_down),
        .q        (y_q)
    );

    blit_slope #(.FRAC_W(FRAC_W)) u_slope (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .advance (wr_fire && line_q),
        .inc     (slope_q),
        .carry   (carry)
    );

    assign dst_addr = base_q + (ADDR_W'(y_q) << X_W) + ADDR_W'(x_q);
    assign new_byte = line_q ? fill_q : srcd_q;

    blit_rop #(.DATA_W(DATA_W)) u_rop (
        .op       (rop_q),
        .new_byte (new_byte),
        .old_byte (dstd_q),
        .result   (comb_byte)
    );

endmodule

// File: rtl/blit_checker.sv
module blit_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int X_W    = 6,
    parameter int Y_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              cfg_mode,
    input logic [X_W:0]      cfg_cols,
    input logic [Y_W:0]      cfg_span,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);
    logic zero_req;
    assign zero_req = cfg_mode ? (cfg_span == '0)
                               : ((cfg_cols == '0) || (cfg_span == '0));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !zero_req) |=> busy);

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_req && mem_gnt && mem_we) || $past(start)));

    assert_busy_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(mem_req && mem_gnt && mem_we)) |=> busy);

    assert_zero_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && zero_req) |=> (done && !busy && !mem_req));

endmodule

bind vecblit_engine blit_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .X_W    (X_W),
    .Y_W    (Y_W)
) u_blit_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_mode  (cfg_mode),
    .cfg_cols  (cfg_cols),
    .cfg_span  (cfg_span),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/vecblit_engine_test.sv
`timescale 1ns/1ps
module vecblit_engine_test;

    typedef struct packed {
        logic        we;
        logic [15:0] addr;
        logic [7:0]  data;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cfg_mode = 1'b0;
    logic [1:0]  cfg_rop = 2'b00;
    logic [2:0]  cfg_octant = 3'b000;
    logic [15:0] cfg_src = '0;
    logic [15:0] cfg_base = '0;
    logic [5:0]  cfg_x0 = '0;
    logic [7:0]  cfg_y0 = '0;
    logic [6:0]  cfg_cols = '0;
    logic [8:0]  cfg_span = '0;
    logic [7:0]  cfg_slope = '0;
    logic [7:0]  cfg_fill = '0;
    logic        busy, done, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_gnt = 1'b0;

    int checks = 0;
    int failures = 0;
    int done_cnt = 0;
    bit stall_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    string cur_tag = "R2";
    txn_t exp_q[$];

    always #5 clk = ~clk;

    function automatic logic [7:0] mdata(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic logic [7:0] rop_f(input logic [1:0] op,
                                         input logic [7:0] n, input logic [7:0] o);
        case (op)
            2'b00:   return n;
            2'b01:   return n | o;
            2'b10:   return n & o;
            default: return n ^ o;
        endcase
    endfunction

    assign mem_rdata = mdata(mem_addr);

    vecblit_engine uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
        .cfg_rop(cfg_rop), .cfg_octant(cfg_octant), .cfg_src(cfg_src),
        .cfg_base(cfg_base), .cfg_x0(cfg_x0), .cfg_y0(cfg_y0),
        .cfg_cols(cfg_cols), .cfg_span(cfg_span), .cfg_slope(cfg_slope),
        .cfg_fill(cfg_fill), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Grant generator: decided shortly after each rising edge
    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_gnt = mem_req && (!stall_en || lfsr[0]);
    end

    // Monitor: a transfer happens at the next rising edge when req && gnt
    bit          prev_pend = 1'b0;
    logic [15:0] prev_addr;
    logic        prev_we;
    logic [7:0]  prev_wd;
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) done_cnt++;
            if (prev_pend) begin
                chk(mem_req && mem_addr == prev_addr && mem_we == prev_we &&
                    (!mem_we || mem_wdata == prev_wd), "R6", "held request",
                    {15'd0, mem_req, mem_addr}, {16'd1, prev_addr});
            end
            prev_pend = mem_req && !mem_gnt;
            prev_addr = mem_addr;
            prev_we   = mem_we;
            prev_wd   = mem_wdata;
            if (mem_req && mem_gnt) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, cur_tag, "unexpected transfer",
                        {7'd0, mem_we, mem_addr, mem_wdata}, 32'd0);
                end else begin
                    txn_t e;
                    e = exp_q.pop_front();
                    chk(mem_we == e.we && mem_addr == e.addr &&
                        (!e.we || mem_wdata == e.data), cur_tag, "transfer",
                        {7'd0, mem_we, mem_addr, mem_wdata},
                        {7'd0, e.we, e.addr, e.data});
                end
            end
        end
    end

    task automatic push(input logic we, input logic [15:0] a, input logic [7:0] d);
        txn_t t;
        t.we = we; t.addr = a; t.data = d;
        exp_q.push_back(t);
    endtask

    // Driver-side expectation from the requirements (R2..R5)
    task automatic build_expect();
        logic [5:0]  xx;
        logic [7:0]  yy;
        logic [7:0]  acc;
        logic [8:0]  sum;
        logic [15:0] a, s;
        if (cfg_mode) begin
            xx = cfg_x0; yy = cfg_y0; acc = '0;
            for (int i = 0; i < int'(cfg_span); i++) begin
                a = cfg_base + {2'b00, yy, 6'b0} + {10'd0, xx};
                if (cfg_rop != 2'b00) push(1'b0, a, 8'h00);
                push(1'b1, a, rop_f(cfg_rop, cfg_fill, mdata(a)));
                sum = {1'b0, acc} + {1'b0, cfg_slope};
                acc = sum[7:0];
                if (cfg_octant[2]) begin
                    yy = cfg_octant[0] ? yy - 8'd1 : yy + 8'd1;
                    if (sum[8]) xx = cfg_octant[1] ? xx - 6'd1 : xx + 6'd1;
                end else begin
                    xx = cfg_octant[1] ? xx - 6'd1 : xx + 6'd1;
                    if (sum[8]) yy = cfg_octant[0] ? yy - 8'd1 : yy + 8'd1;
                end
            end
        end else begin
            s = cfg_src;
            for (int r = 0; r < int'(cfg_span); r++) begin
                for (int c = 0; c < int'(cfg_cols); c++) begin
                    yy = cfg_y0 + 8'(r);
                    xx = cfg_x0 + 6'(c);
                    a = cfg_base + {2'b00, yy, 6'b0} + {10'd0, xx};
                    push(1'b0, s, 8'h00);
                    if (cfg_rop != 2'b00) push(1'b0, a, 8'h00);
                    push(1'b1, a, rop_f(cfg_rop, mdata(s), mdata(a)));
                    s = s + 16'd1;
                end
            end
        end
    endtask

    task automatic run_op(input string tag, input bit zero, input bit inject);
        int cnt;
        int d0;
        cur_tag = tag;
        if (!zero) build_expect();
        d0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (zero) begin
            chk(done && !busy && !mem_req, "R9", "zero-length done, idle",
                {30'd0, done, busy}, 32'd2);
            @(negedge clk);
            chk(!done && !busy, "R9", "zero-length single pulse",
                {30'd0, done, busy}, 32'd0);
            return;
        end
        chk(busy, "R7", "busy after start", {31'd0, busy}, 32'd1);
        if (inject) begin
            repeat (3) @(negedge clk);
            chk(busy, "R8", "still busy before second start", {31'd0, busy}, 32'd1);
            cfg_mode = ~cfg_mode; cfg_base = cfg_base ^ 16'h1234;
            cfg_x0 = cfg_x0 + 6'd7; cfg_rop = ~cfg_rop;
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        cnt = 0;
        while (!done && cnt < 20000) begin
            @(negedge clk);
            cnt++;
        end
        chk(done, "R7", "done seen", {31'd0, done}, 32'd1);
        chk(!busy, "R7", "busy low with done", {31'd0, busy}, 32'd0);
        chk(exp_q.size() == 0, tag, "all expected transfers done",
            exp_q.size(), 32'd0);
        @(negedge clk);
        chk(!done, "R7", "done one cycle", {31'd0, done}, 32'd0);
        if (inject) begin
            repeat (6) @(negedge clk);
            chk(!busy && (done_cnt - d0) == 1, "R8", "no second operation",
                done_cnt - d0, 32'd1);
        end
        exp_q.delete();
    endtask

    task automatic set_block(input logic [1:0] rop, input logic [15:0] src,
                             input logic [15:0] base, input logic [5:0] x0,
                             input logic [7:0] y0, input logic [6:0] cols,
                             input logic [8:0] rows);
        cfg_mode = 1'b0; cfg_rop = rop; cfg_src = src; cfg_base = base;
        cfg_x0 = x0; cfg_y0 = y0; cfg_cols = cols; cfg_span = rows;
    endtask

    task automatic set_line(input logic [1:0] rop, input logic [2:0] oct,
                            input logic [15:0] base, input logic [5:0] x0,
                            input logic [7:0] y0, input logic [8:0] len,
                            input logic [7:0] slope, input logic [7:0] fill);
        cfg_mode = 1'b1; cfg_rop = rop; cfg_octant = oct; cfg_base = base;
        cfg_x0 = x0; cfg_y0 = y0; cfg_span = len; cfg_slope = slope;
        cfg_fill = fill;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R7", "watchdog expired", 32'd0, 32'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mem_req, "R1", "reset outputs",
            {29'd0, busy, done, mem_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !mem_req, "R1", "idle after reset",
            {30'd0, busy, mem_req}, 32'd0);

        // R2: plain block copy, rows and columns
        stall_en = 1'b0;
        set_block(2'b00, 16'h0400, 16'h8000, 6'd10, 8'd5, 7'd4, 9'd3);
        run_op("R2", 1'b0, 1'b0);
        // R2: column wrap modulo 64, with stalls (R6)
        stall_en = 1'b1;
        set_block(2'b00, 16'h1000, 16'h4000, 6'd62, 8'd255, 7'd4, 9'd2);
        run_op("R2", 1'b0, 1'b0);
        // R3: OR, AND, XOR read-modify-write under stalls
        set_block(2'b01, 16'h2000, 16'h0000, 6'd1, 8'd2, 7'd3, 9'd2);
        run_op("R3", 1'b0, 1'b0);
        set_block(2'b10, 16'h2100, 16'h0100, 6'd20, 8'd9, 7'd2, 9'd3);
        run_op("R3", 1'b0, 1'b0);
        set_block(2'b11, 16'h2200, 16'h0200, 6'd33, 8'd40, 7'd5, 9'd1);
        run_op("R3", 1'b0, 1'b0);
        // R4/R5: lines in several octants
        stall_en = 1'b0;
        set_line(2'b00, 3'b000, 16'h8000, 6'd3, 8'd10, 9'd10, 8'h60, 8'hFF);
        run_op("R4", 1'b0, 1'b0);
        stall_en = 1'b1;
        set_line(2'b11, 3'b111, 16'h8000, 6'd30, 8'd100, 9'd12, 8'hC0, 8'h81);
        run_op("R5", 1'b0, 1'b0);
        set_line(2'b01, 3'b010, 16'h6000, 6'd2, 8'd3, 9'd9, 8'hFF, 8'h0F);
        run_op("R5", 1'b0, 1'b0);
        set_line(2'b10, 3'b101, 16'h6000, 6'd40, 8'd1, 9'd6, 8'h55, 8'hF0);
        run_op("R5", 1'b0, 1'b0);
        set_line(2'b00, 3'b001, 16'h3000, 6'd7, 8'd7, 9'd1, 8'h80, 8'h3C);
        run_op("R4", 1'b0, 1'b0);
        // R8: second start while busy is ignored
        set_block(2'b01, 16'h5000, 16'h9000, 6'd5, 8'd6, 7'd6, 9'd4);
        run_op("R8", 1'b0, 1'b1);
        // R9: zero lengths
        stall_en = 1'b0;
        set_block(2'b00, 16'h0000, 16'h0000, 6'd0, 8'd0, 7'd0, 9'd3);
        run_op("R9", 1'b1, 1'b0);
        set_block(2'b01, 16'h0000, 16'h0000, 6'd0, 8'd0, 7'd5, 9'd0);
        run_op("R9", 1'b1, 1'b0);
        set_line(2'b00, 3'b000, 16'h0000, 6'd0, 8'd0, 9'd0, 8'h10, 8'h11);
        run_op("R9", 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        chk(!busy && !mem_req, "R1", "quiet at end", {30'd0, busy, mem_req}, 32'd0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule